// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Infrared Pulse Encoding

This block serialises one byte at a time onto a single output pin as an asynchronous frame. It runs directly on the serial-interface clock, which may come from a baud-rate timer or from an external clock pin. Each bit on the line lasts one oversampling period. That period is either 16 or 8 input clocks, chosen by a divide-select input.

The output can be plain NRZ, which idles high. It can also be infrared-style return-to-zero pulses, where only zero bits produce a short pulse centred in the bit. A polarity input flips the pulse direction and the idle level to match the external optical transceiver.

A write is accepted only while the block is idle. A busy output covers the whole frame. The divide ratio is captured when the write is accepted. The encoding mode and the polarity act on the pin at once.

Top module: `async_ir_tx`

## Requirements
- R1: After reset, busy is low and txd is high. This holds with IrDA mode off, and with IrDA mode on and not inverted.
- R2: A frame is one start bit (0), then DATA_W data bits with the least significant bit first, then one stop bit (1). With IrDA mode off, txd shows each bit value for its whole bit time and idles high.
- R3: With div8_sel = 0 at the accepted write, every bit lasts 16 clocks, so busy is high for 160 clocks at DATA_W = 8.
- R4: With div8_sel = 1 at the accepted write, every bit lasts 8 clocks, so busy is high for 80 clocks at DATA_W = 8.
- R5: The divide ratio is taken from div8_sel in the cycle of the accepted write. A change of div8_sel during a frame leaves that frame's timing unchanged.
- R6: busy goes high in the clock after an accepted write (wr_en high while busy is low). It falls in the clock after the last clock of the stop bit.
- R7: wr_en while busy is high is ignored. The frame in progress continues unchanged and no second frame follows.
- R8: With irda_en = 1 and ir_invert = 0, a zero bit drives txd low only in bit phases 6..8 at divide 16, or phases 3..4 at divide 8. Phase 0 is the first clock of the bit. At all other times txd is high.
- R9: With irda_en = 1 and ir_invert = 1, txd is the complement of the R8 waveform: a high pulse for zero bits, and low otherwise, including when idle.
- R10: With irda_en = 0, ir_invert has no effect on txd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial-interface input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for a byte |
| wr_data | input | DATA_W | Byte to transmit |
| div8_sel | input | 1 | 0: 16 clocks per bit, 1: 8 clocks per bit |
| irda_en | input | 1 | 1: infrared pulse encoding, 0: NRZ |
| ir_invert | input | 1 | Inverts pulse polarity and idle level in IrDA mode |
| busy | output | 1 | High while a frame is in progress |
| txd | output | 1 | Serial data output |

## Verification
The bench builds the block with the default DATA_W = 8. This gives the full 10-bit frame at both oversampling ratios, so the expected busy lengths are 160 and 80 clocks. The bench moves the run-time inputs while frames are in progress: it changes the divide select mid-frame, sends writes while busy, and switches the IrDA mode and polarity live. This exercises capture-at-write and the pulse windows at both ratios against a per-clock queue model.

// File: rtl/async_ir_tx.sv
module async_ir_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              div8_sel,
  input  logic              irda_en,
  input  logic              ir_invert,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bits_left;
  logic [3:0]         phase;
  logic               div8_q;
  logic               busy_q;

  wire [3:0] last_phase = div8_q ? 4'd7 : 4'd15;
  wire [3:0] win_lo     = div8_q ? 4'd3 : 4'd6;
  wire [3:0] win_hi     = div8_q ? 4'd4 : 4'd8;
  wire       bit_end    = busy_q && (phase == last_phase);
  wire       take       = wr_en && !busy_q;
  wire       cur_bit    = shreg[0];
  wire       ir_pulse   = busy_q && !cur_bit && (phase >= win_lo) && (phase <= win_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      phase     <= '0;
      div8_q    <= 1'b0;
    end else if (take) begin
      busy_q    <= 1'b1;
      shreg     <= {1'b1, wr_data, 1'b0};
      bits_left <= LAST_BIT;
      phase     <= '0;
      div8_q    <= div8_sel;
    end else if (busy_q) begin
      if (bit_end) begin
        phase <= '0;
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        if (bits_left == '0) busy_q <= 1'b0;
        else                 bits_left <= bits_left - 1'b1;
      end else begin
        phase <= phase + 4'd1;
      end
    end
  end

  assign busy = busy_q;
  assign txd  = irda_en ? (ir_invert ? ir_pulse : ~ir_pulse) : cur_bit;

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wr_en));
  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(phase) == $past(last_phase)) && ($past(bits_left) == '0));
  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(div8_q));
  // R2
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> cur_bit);
  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= last_phase);
  // R7
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(bit_end && bits_left == '0)) |=> busy_q);
endmodule

// File: tb/test_async_ir_tx.sv
module test_async_ir_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       div8_sel = 1'b0;
  logic       irda_en = 1'b0;
  logic       ir_invert = 1'b0;
  logic       busy, txd;

  int checks = 0, failures = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  async_ir_tx #(.DATA_W(8)) i_async_ir_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .div8_sel(div8_sel), .irda_en(irda_en), .ir_invert(ir_invert),
    .busy(busy), .txd(txd));

  bit m_busy = 1'b0;
  bit m_bits[$];
  int m_phase = 0;
  int m_n = 16;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_bits.delete(); m_phase = 0;
    end else if (!m_busy && wr_en) begin
      m_bits.delete();
      m_bits.push_back(1'b0);
      for (int i = 0; i < 8; i++) m_bits.push_back(wr_data[i]);
      m_bits.push_back(1'b1);
      m_n = div8_sel ? 8 : 16;
      m_phase = 0;
      m_busy = 1'b1;
    end else if (m_busy) begin
      if (m_phase == m_n - 1) begin
        void'(m_bits.pop_front());
        m_phase = 0;
        if (m_bits.size() == 0) m_busy = 1'b0;
      end else m_phase++;
    end
  end

  function automatic bit exp_txd();
    bit b, pulse;
    int lo, hi;
    b = m_busy ? m_bits[0] : 1'b1;
    lo = (m_n == 8) ? 3 : 6;
    hi = (m_n == 8) ? 4 : 8;
    pulse = m_busy && !b && m_phase >= lo && m_phase <= hi;
    if (!irda_en) return b;
    return ir_invert ? pulse : !pulse;
  endfunction

  task automatic check(bit act, bit exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      check(busy, m_busy, "R6");
      check(txd, exp_txd(), irda_en ? (ir_invert ? "R9" : "R8") : (ir_invert ? "R10" : "R2"));
    end
  end

  task automatic count_check(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sends a byte; optionally toggles div8_sel and issues a write while busy
  task automatic frame(logic [7:0] d, bit d8, bit disturb, int exp_len, string req);
    int len = 0;
    @(negedge clk);
    div8_sel = d8; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    while (busy) begin
      len++;
      if (disturb && len == 20) begin div8_sel = !d8; wr_data = 8'h00; wr_en = 1'b1; end
      if (disturb && len == 21) wr_en = 1'b0;
      @(negedge clk);
    end
    count_check(len, exp_len, req);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy, 1'b0, "R1");
    check(txd, 1'b1, "R1");
    irda_en = 1'b1;
    @(negedge clk);
    check(txd, 1'b1, "R1");
    irda_en = 1'b0;
    running = 1'b1;
    frame(8'hA5, 1'b0, 1'b0, 160, "R3");
    frame(8'h3C, 1'b1, 1'b0, 80, "R4");
    frame(8'h81, 1'b0, 1'b1, 160, "R5");
    frame(8'h7E, 1'b1, 1'b1, 80, "R7");
    ir_invert = 1'b1;
    frame(8'h55, 1'b0, 1'b0, 160, "R10");
    irda_en = 1'b1;
    frame(8'h00, 1'b0, 1'b0, 160, "R9");
    frame(8'hF0, 1'b1, 1'b0, 80, "R9");
    ir_invert = 1'b0;
    frame(8'h00, 1'b1, 1'b0, 80, "R8");
    frame(8'h96, 1'b0, 1'b1, 160, "R8");
    irda_en = 1'b0;
    frame(8'hFF, 1'b0, 1'b0, 160, "R2");
    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule